// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two 20-bit unsigned operands and a single carry bit and returns a 20-bit sum with a carry-out. The carry path is split into five groups whose widths grow by one bit at a time from the least significant end: two bits, then three, four, five and six. The lowest group is a plain ripple chain fed by the carry input. Every higher group runs two ripple chains side by side, one that assumes no carry arrives and one that assumes a carry arrives. The real carry leaving the group below then picks one of the two results with a multiplexer. The longest path therefore crosses one short ripple chain and a chain of four multiplexers, rather than twenty carry stages.

Each bit first forms a propagate term (the XOR of the operand bits) and a generate term (their AND). Inside a group the carry into bit k+1 is the generate of bit k OR'd with the propagate of bit k AND'd with the carry into bit k. The sum bit is the propagate XOR'd with the carry into that bit.

Operands enter through a valid/ready handshake and the result leaves through one registered stage with its own valid/ready handshake. An operand set is taken in any cycle where `in_valid` and `in_ready` are both high. The result appears on the following cycle and stays frozen until the consumer raises `out_ready`. The stage can take a new operand set in the same cycle that its current result drains, so a steady stream moves at one result per cycle.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every accepted operand set, `{out_carry, out_sum}` equals the 21-bit value A + B + carry-in, with the carry-out as bit 20.
- R2: Carries cross each group boundary correctly. The group boundaries fall below bits 2, 5, 9 and 14, and the groups cover bits 0-1, 2-4, 5-8, 9-13 and 14-19. A low run of ones ending just below a boundary, plus 1, gives a sum with only the boundary bit set.
- R3: A carry that ripples through all five groups is correct. All ones plus carry-in 1 gives sum 0 and carry-out 1. 0xAAAAA plus 0x55555 with carry-in 1 gives the same result.
- R4: An operand set accepted at a clock edge is presented with `out_valid` high after that edge, one cycle of latency.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sum` and `out_carry` hold their values, and `in_ready` is low so no operand set is taken.
- R6: `in_ready` is high whenever the output stage is empty or is draining. An acceptance and a drain in the same cycle lose no result and duplicate none.
- R7: While reset is asserted (`rst_n` low) and on leaving it, `out_valid` is 0 and `in_ready` is 1.
- R8: The carry input alone is added. Zero operands with carry-in 1 give sum 1 and carry-out 0; with carry-in 0 they give sum 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| in_a | input | 20 | First operand |
| in_b | input | 20 | Second operand |
| in_carry | input | 1 | Carry input |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 20 | Sum bits |
| out_carry | output | 1 | Carry-out (bit 20 of the full sum) |

## Verification
The two events that can fall in the same cycle are taking a new operand set and draining the held result. The bench provokes this by streaming back-to-back operand sets with `out_ready` held high. It also releases `out_ready` on the same edge where a stalled operand set is still waiting. In each case it requires every result to appear exactly once, in order, in the cycle after its own acceptance, with the expected sum and carry. The add itself is judged against a 21-bit addition that the bench computes, for boundary-crossing carries, full-width ripples and a fixed-seed run of random operands.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;
  // Width of group g when the first group holds 'first' bits and each
  // later group is one bit wider than its neighbour below.
  function automatic int grp_width(input int first, input int g);
    return first + g;
  endfunction

  // Position of the least significant bit of group g.
  function automatic int grp_lsb(input int first, input int g);
    return g * first + (g * (g - 1)) / 2;
  endfunction

  // Total operand width covered by n groups.
  function automatic int total_width(input int first, input int n);
    return grp_lsb(first, n);
  endfunction
endpackage

// File: rtl/sqcs_pg_setup.sv
module sqcs_pg_setup #(
  parameter int WIDTH = 20
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = a[i] ^ b[i];
    assign gen[i]  = a[i] & b[i];
  end
endmodule

// File: rtl/sqcs_ripple_group.sv
module sqcs_ripple_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < W; i++) begin
      sum[i] = prop[i] ^ c;
      c      = gen[i] | (prop[i] & c);
    end
    cout = c;
  end
endmodule

// File: rtl/sqcs_select_group.sv
module sqcs_select_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  input  logic         sel,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] sum_lo, sum_hi;
  logic         cout_lo, cout_hi;

  sqcs_ripple_group #(.W(W)) u_assume0 (
    .prop(prop), .gen(gen), .cin(1'b0), .sum(sum_lo), .cout(cout_lo)
  );
  sqcs_ripple_group #(.W(W)) u_assume1 (
    .prop(prop), .gen(gen), .cin(1'b1), .sum(sum_hi), .cout(cout_hi)
  );

  assign sum  = sel ? sum_hi  : sum_lo;
  assign cout = sel ? cout_hi : cout_lo;

  // R2: a carry leaving the no-carry chain must also leave the carry chain,
  // and the two chains' sums differ by exactly the incoming carry.
  always_comb begin
    assert_carry_order_R2: assert (!cout_lo || cout_hi)
      else $error("carry order broken in select group");
    assert_chain_pair_R2: assert ({cout_hi, sum_hi} == {cout_lo, sum_lo} + 1'b1)
      else $error("assume-0 and assume-1 chains disagree");
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import sqcs_pkg::*;
#(
  parameter int FIRST_GROUP = 2,
  parameter int NUM_GROUPS  = 5,
  parameter int WIDTH       = total_width(FIRST_GROUP, NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry
);
  logic [WIDTH-1:0]    prop, gen, sum_c;
  logic [NUM_GROUPS:0] grp_carry;

  sqcs_pg_setup #(.WIDTH(WIDTH)) u_setup (
    .a(in_a), .b(in_b), .prop(prop), .gen(gen)
  );

  assign grp_carry[0] = in_carry;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LSB = grp_lsb(FIRST_GROUP, g);
    localparam int W   = grp_width(FIRST_GROUP, g);
    if (g == 0) begin : g_base
      sqcs_ripple_group #(.W(W)) u_rip (
        .prop(prop[LSB +: W]), .gen(gen[LSB +: W]), .cin(grp_carry[g]),
        .sum(sum_c[LSB +: W]), .cout(grp_carry[g+1])
      );
    end else begin : g_sel
      sqcs_select_group #(.W(W)) u_sel (
        .prop(prop[LSB +: W]), .gen(gen[LSB +: W]), .sel(grp_carry[g]),
        .sum(sum_c[LSB +: W]), .cout(grp_carry[g+1])
      );
    end
  end

  // Output stage: one register, takes new data when empty or draining.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum   <= sum_c;
        out_carry <= grp_carry[NUM_GROUPS];
      end
    end
  end

  // R1: registered result matches a plain wide addition of the accepted operands.
  assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      ({out_carry, out_sum} == ({1'b0, $past(in_a)} + {1'b0, $past(in_b)}
                                + {{WIDTH{1'b0}}, $past(in_carry)})))
    else $error("sum mismatch");

  // R4: acceptance yields a valid result on the next cycle.
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("result not presented");

  // R5: a stalled result holds.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)))
    else $error("stalled result changed");

  // R6: an empty stage with nothing offered stays empty.
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid)
    else $error("phantom result");
endmodule

// File: tb/sqrt_csel_adder_test.sv
`timescale 1ns/1ps
module sqrt_csel_adder_test;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_carry = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_sum;
  logic         out_carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sqrt_csel_adder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input logic [W:0] act, input logic [W:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Single transfer with the consumer always ready.
  task automatic xfer(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                      input string what);
    @(negedge clk);
    in_a = a; in_b = b; in_carry = c; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({20'd0, out_valid}, 21'd1, {what, " valid R4"});
    check({out_carry, out_sum}, model(a, b, c), what);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({19'd0, out_valid, in_ready}, 21'd1, "reset state R7");
    rst_n = 1'b1;
    @(negedge clk);
    check({19'd0, out_valid, in_ready}, 21'd1, "after reset R7");
  endtask

  task automatic t_carry_in();
    xfer('0, '0, 1'b1, "carry-in only R8");
    xfer('0, '0, 1'b0, "zero add R8");
  endtask

  task automatic t_boundaries();
    int bnd[4] = '{2, 5, 9, 14};
    foreach (bnd[i]) begin
      xfer((20'd1 << bnd[i]) - 20'd1, 20'd1, 1'b0, $sformatf("boundary %0d R2", bnd[i]));
      xfer((20'd1 << bnd[i]) - 20'd1, 20'd0, 1'b1, $sformatf("boundary cin %0d R2", bnd[i]));
    end
  endtask

  task automatic t_full_ripple();
    xfer(20'hFFFFF, 20'h00000, 1'b1, "all ones plus cin R3");
    xfer(20'hAAAAA, 20'h55555, 1'b1, "alternating plus cin R3");
    xfer(20'hFFFFF, 20'hFFFFF, 1'b1, "all ones both R3");
    xfer(20'hFFFFF, 20'h00000, 1'b0, "all ones no cin R3");
    xfer(20'hAAAAA, 20'hAAAAA, 1'b0, "alternating doubled R1");
  endtask

  task automatic t_random();
    void'($urandom(32'h1234));
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      logic c;
      a = W'($urandom); b = W'($urandom); c = 1'($urandom);
      xfer(a, b, c, $sformatf("random %0d R1", i));
    end
  endtask

  task automatic t_stall();
    logic [W:0] first;
    first = model(20'h12345, 20'h0F0F0, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 20'h12345; in_b = 20'h0F0F0; in_carry = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_a = 20'h00FFF; in_b = 20'h00001; in_carry = 1'b0;
    check({20'd0, in_ready}, 21'd0, "stall blocks input R5");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check({out_carry, out_sum}, first, "stall holds result R5");
      check({20'd0, out_valid}, 21'd1, "stall holds valid R5");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({20'd0, out_valid}, 21'd1, "drain and accept R6");
    check({out_carry, out_sum}, model(20'h00FFF, 20'h00001, 1'b0), "second result R6");
    @(negedge clk);
    check({20'd0, out_valid}, 21'd0, "stage empties R6");
  endtask

  task automatic t_stream();
    logic [W-1:0] va[4] = '{20'h80000, 20'h7FFFF, 20'h3FFF, 20'h00003};
    logic [W-1:0] vb[4] = '{20'h80000, 20'h00001, 20'h04000, 20'hFFFFD};
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      in_a = va[i]; in_b = vb[i]; in_carry = i[0]; in_valid = 1'b1;
      @(negedge clk);
      check({20'd0, in_ready}, 21'd1, "stream ready R6");
      check({out_carry, out_sum}, model(va[i], vb[i], i[0]),
            $sformatf("stream item %0d R6", i));
    end
    in_valid = 1'b0;
    @(negedge clk);
    check({20'd0, out_valid}, 21'd0, "stream ends empty R6");
  endtask

  initial begin
    t_reset();
    t_carry_in();
    t_boundaries();
    t_full_ripple();
    t_stall();
    t_stream();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule